// File: doc/BRIEF.md
# Dual-Output Routed Interrupt Aggregator

This block gathers 224 interrupt inputs and presents them to a host as two level interrupt lines. The inputs are packed into seven 32-bit words, and every source has four configuration bits: edge or level triggering, the active polarity, which output it drives, and an enable. Each raw input passes through a two-flop synchronizer. An edge source latches a pending flag on its selected edge, and software drops that flag with a write-one-to-clear. A level source is pending for as long as its input sits at the active level.

Pending sources that are enabled are split by the routing bit into two sets of seven masked-pending words, one set per output. A summary word shows which of those words are nonzero. A service routine reads the summary first, then the one masked word it points to, so it reaches the highest-numbered pending source in two reads. A plain register bus (address, write data, write enable, combinational read data) reaches both banks. Address bit 8 selects the bank: 0 is the configuration bank and 1 is the status bank.

Top module: `intc_dual_route`

## Requirements
- R1: After reset every type bit reads 1 (edge) and every routing bit reads 1 (output 0). Every polarity bit and every enable bit reads 0. Both outputs are low.
- R2: The configuration bank (address bit 8 = 0) holds seven words per array, read/write, at byte offsets 0x00+4w (type), 0x1C+4w (polarity), 0x38+4w (routing) and 0x54+4w (enable), for w = 0..6.
- R3: When the type bit is 1, the source latches pending on a rising input edge if polarity is 0, or on a falling edge if polarity is 1. The flag stays set after the input returns to its inactive level.
- R4: Writing the status bank at offset 0x00+4w clears the latched pending flag of every source in word w whose write-data bit is 1. Bits written 0 leave their sources unchanged.
- R5: When the type bit is 0, the source is pending exactly while its synchronized input is high (polarity 0) or low (polarity 1). It is never latched.
- R6: An enabled pending source whose routing bit is 1 appears in the output-0 masked word at status offset 0x38+4w. If the routing bit is 0, it appears in the output-1 masked word at 0x1C+4w. It never appears in both.
- R7: A source whose enable bit is 0 appears in no masked word and drives no output. An edge flag latched while the source is masked shows up once the source is enabled.
- R8: The status word at offset 0x7C has bit w (w = 0..6) set when output-1 masked word w is nonzero, and bit 8+w set when output-0 masked word w is nonzero. All other bits are 0.
- R9: irq_out0 is high exactly when any of summary bits [14:8] is set. irq_out1 is high exactly when any of summary bits [6:0] is set.
- R10: The following all read as zero: unmapped offsets, offsets that are not a multiple of four, and the clear array. Writes to the masked words, the summary word and unmapped offsets change nothing.
- R11: Source n occupies word n/32, bit n%32, in every array and masked word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 224 | Raw interrupt inputs, source n on bit n |
| bus_addr | input | 9 | Byte address; bit 8 selects the bank (0 configuration, 1 status) |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out0 | output | 1 | Level interrupt for sources routed with routing bit 1 |
| irq_out1 | output | 1 | Level interrupt for sources routed with routing bit 0 |

## Verification
Every one of the 224 sources is configured and toggled on its own. The source number selects one of the four type/polarity combinations and one of the two routes, so the sweep shows three things: a wrong word or bit position, edge behaviour that differs from level, and rising behaviour that differs from falling. The masked words of both outputs, the summary and both pins are read, so a misroute into the other output, or into both, is caught. Separate patterns pend two sources in different words and clear only one, which separates a per-bit clear from a per-word clear. They also latch an edge while its source is masked, which separates gating at the mask from gating at the latch.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int unsigned NUM_WORDS = 7;
    parameter int unsigned WORD_W    = 32;
    parameter int unsigned ADDR_W    = 9;

    // configuration arrays, in their address order
    typedef enum logic [1:0] {
        ARR_TYPE  = 2'd0,
        ARR_POL   = 2'd1,
        ARR_ROUTE = 2'd2,
        ARR_EN    = 2'd3
    } cfg_arr_e;

    localparam int unsigned SUMMARY_OFF = 32'h7C;
    localparam int unsigned OUT0_SHIFT  = 8;
endpackage

// File: rtl/intc_sync_detect.sv
module intc_sync_detect
    import intc_pkg::*;
#(
    parameter int unsigned NW = NUM_WORDS,
    parameter int unsigned W  = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0][W-1:0] src_w,
    input  logic [NW-1:0][W-1:0] pol,
    output logic [NW-1:0][W-1:0] lvl_act,
    output logic [NW-1:0][W-1:0] edge_act
);
    logic [NW-1:0][W-1:0] s1_q, s2_q, s3_q;

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[w] <= '0;
                s2_q[w] <= '0;
                s3_q[w] <= '0;
            end else begin
                s1_q[w] <= src_w[w];
                s2_q[w] <= s1_q[w];
                s3_q[w] <= s2_q[w];
            end
        end
        // the previous sample is judged with the current polarity, so a
        // polarity write alone never looks like an edge
        assign lvl_act[w]  = s2_q[w] ^ pol[w];
        assign edge_act[w] = lvl_act[w] & ~(s3_q[w] ^ pol[w]);
    end
endmodule

// File: rtl/intc_cfg_bank.sv
module intc_cfg_bank
    import intc_pkg::*;
#(
    parameter int unsigned NW    = NUM_WORDS,
    parameter int unsigned W     = WORD_W,
    localparam int unsigned IDX_W = $clog2(NW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  cfg_arr_e             sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic [W-1:0]         wdata,
    output logic [NW-1:0][W-1:0] typ,
    output logic [NW-1:0][W-1:0] pol,
    output logic [NW-1:0][W-1:0] route,
    output logic [NW-1:0][W-1:0] en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            typ   <= '1;
            pol   <= '0;
            route <= '1;
            en    <= '0;
        end else if (we) begin
            unique case (sel)
                ARR_TYPE:  typ[idx]   <= wdata;
                ARR_POL:   pol[idx]   <= wdata;
                ARR_ROUTE: route[idx] <= wdata;
                ARR_EN:    en[idx]    <= wdata;
            endcase
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(typ) && $stable(pol) && $stable(route) && $stable(en))); // R2
endmodule

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
#(
    parameter int unsigned NW = NUM_WORDS,
    parameter int unsigned W  = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0][W-1:0] typ,
    input  logic [NW-1:0][W-1:0] lvl_act,
    input  logic [NW-1:0][W-1:0] edge_act,
    input  logic [NW-1:0][W-1:0] clr,
    output logic [NW-1:0][W-1:0] raw_pend
);
    logic [NW-1:0][W-1:0] pend_q;

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= typ & ((pend_q & ~clr) | edge_act);
    end

    assign raw_pend = (typ & pend_q) | (~typ & lvl_act);

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(pend_q) & $past(typ) & ~$past(clr)) & typ & ~pend_q) == '0)); // R3
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(clr) & ~$past(edge_act)) & pend_q) == '0)); // R4
endmodule

// File: rtl/intc_dual_route.sv
module intc_dual_route
    import intc_pkg::*;
#(
    parameter int unsigned NW     = NUM_WORDS,
    parameter int unsigned W      = WORD_W,
    parameter int unsigned AW     = ADDR_W,
    localparam int unsigned NSRC  = NW * W,
    localparam int unsigned IDX_W = $clog2(NW),
    localparam int        SPAN    = int'(NW) * 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [AW-1:0]   bus_addr,
    input  logic [W-1:0]    bus_wdata,
    input  logic            bus_we,
    output logic [W-1:0]    bus_rdata,
    output logic            irq_out0,
    output logic            irq_out1
);
    logic [NW-1:0][W-1:0] src_w, typ, pol, route, en;
    logic [NW-1:0][W-1:0] lvl_act, edge_act, raw_pend, clr;
    logic [NW-1:0][W-1:0] out0_w, out1_w;
    logic [NW-1:0]        sum0, sum1;
    logic [W-1:0]         summary;

    logic [AW-2:0]    off;
    logic             bank;
    logic             cfg_hit, st_hit, sum_hit;
    cfg_arr_e         cfg_sel;
    logic [1:0]       st_sel;
    logic [IDX_W-1:0] idx;

    assign src_w = src_i;
    assign off   = bus_addr[AW-2:0];
    assign bank  = bus_addr[AW-1];

    // address decode: up to four arrays of NW words in each bank
    always_comb begin
        cfg_hit = 1'b0;
        st_hit  = 1'b0;
        cfg_sel = ARR_TYPE;
        st_sel  = 2'd0;
        idx     = '0;
        for (int k = 0; k < 4; k++) begin
            if (int'(off) >= k * SPAN && int'(off) < (k + 1) * SPAN && off[1:0] == 2'b00) begin
                idx = IDX_W'((int'(off) - k * SPAN) >> 2);
                if (!bank) begin
                    cfg_hit = 1'b1;
                    cfg_sel = cfg_arr_e'(2'(k));
                end else if (k < 3) begin
                    st_hit = 1'b1;
                    st_sel = 2'(k);
                end
            end
        end
        sum_hit = bank && (int'(off) == int'(SUMMARY_OFF));
    end

    always_comb begin
        clr = '0;
        if (bus_we && st_hit && st_sel == 2'd0) clr[idx] = bus_wdata;
    end

    intc_cfg_bank #(.NW(NW), .W(W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(bus_we && cfg_hit), .sel(cfg_sel),
        .idx(idx), .wdata(bus_wdata),
        .typ(typ), .pol(pol), .route(route), .en(en)
    );

    intc_sync_detect #(.NW(NW), .W(W)) sync_i (
        .clk(clk), .rst_n(rst_n), .src_w(src_w), .pol(pol),
        .lvl_act(lvl_act), .edge_act(edge_act)
    );

    intc_pending #(.NW(NW), .W(W)) pend_i (
        .clk(clk), .rst_n(rst_n), .typ(typ), .lvl_act(lvl_act),
        .edge_act(edge_act), .clr(clr), .raw_pend(raw_pend)
    );

    for (genvar w = 0; w < NW; w++) begin : g_route
        assign out0_w[w] = raw_pend[w] & en[w] & route[w];
        assign out1_w[w] = raw_pend[w] & en[w] & ~route[w];
        assign sum0[w]   = |out0_w[w];
        assign sum1[w]   = |out1_w[w];
    end

    assign summary  = W'(sum1) | (W'(sum0) << OUT0_SHIFT);
    assign irq_out0 = |sum0;
    assign irq_out1 = |sum1;

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            unique case (cfg_sel)
                ARR_TYPE:  bus_rdata = typ[idx];
                ARR_POL:   bus_rdata = pol[idx];
                ARR_ROUTE: bus_rdata = route[idx];
                ARR_EN:    bus_rdata = en[idx];
            endcase
        end else if (st_hit && st_sel == 2'd1) begin
            bus_rdata = out1_w[idx];
        end else if (st_hit && st_sel == 2'd2) begin
            bus_rdata = out0_w[idx];
        end else if (sum_hit) begin
            bus_rdata = summary;
        end
    end

    AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_w & out1_w) == '0); // R6
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((out0_w | out1_w) & ~en) == '0); // R7
    AST_IRQ0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out0 |-> (out0_w == '0)); // R9
    AST_IRQ1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out1 |-> (out1_w == '0)); // R9
endmodule

// File: tb/intc_dual_route_tb.sv
module intc_dual_route_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [223:0] src_i = '0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_rdata;
    logic         irq_out0, irq_out1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_dual_route dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .irq_out0(irq_out0), .irq_out1(irq_out1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit bank, input int off, input logic [31:0] d);
        @(negedge clk);
        bus_addr = {bank, 8'(off)};
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input bit bank, input int off, output logic [31:0] d);
        @(negedge clk);
        bus_addr = {bank, 8'(off)};
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int w = 0; w < 7; w++) wr(1, 4 * w, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int w = 0; w < 7; w++) begin
            rd(0, 8'h00 + 4 * w, v); chk("R1 type", v, 32'hFFFF_FFFF);
            rd(0, 8'h1C + 4 * w, v); chk("R1 pol", v, 32'h0);
            rd(0, 8'h38 + 4 * w, v); chk("R1 route", v, 32'hFFFF_FFFF);
            rd(0, 8'h54 + 4 * w, v); chk("R1 en", v, 32'h0);
        end
        chk("R1 irq", {30'd0, irq_out0, irq_out1}, 32'h0);

        // R2: read/write every configuration word
        for (int k = 0; k < 4; k++)
            for (int w = 0; w < 7; w++)
                wr(0, k * 28 + 4 * w, 32'h5A00_0000 ^ (k << 12) ^ (w * 32'h0101_0101));
        for (int k = 0; k < 4; k++)
            for (int w = 0; w < 7; w++) begin
                rd(0, k * 28 + 4 * w, v);
                chk("R2 cfg rw", v, 32'h5A00_0000 ^ (k << 12) ^ (w * 32'h0101_0101));
            end
        for (int w = 0; w < 7; w++) begin
            wr(0, 8'h54 + 4 * w, 32'h0);
            wr(0, 8'h00 + 4 * w, 32'hFFFF_FFFF);
            wr(0, 8'h1C + 4 * w, 32'h0);
            wr(0, 8'h38 + 4 * w, 32'hFFFF_FFFF);
        end
        settle();
        clear_all();

        // sweep every source: mode from n[1:0], route from n[2]
        for (int n = 0; n < 224; n++) begin
            int w, b;
            bit typ, pol, rt;
            logic [31:0] bm;
            w = n / 32; b = n % 32; bm = 32'h1 << b;
            typ = n[0]; pol = n[1]; rt = n[2];
            src_i[n] = pol;
            settle();
            wr(0, 8'h1C + 4 * w, pol ? bm : 32'h0);
            wr(0, 8'h00 + 4 * w, typ ? 32'hFFFF_FFFF : ~bm);
            wr(0, 8'h38 + 4 * w, rt ? 32'hFFFF_FFFF : ~bm);
            wr(1, 8'h00 + 4 * w, bm);
            wr(0, 8'h54 + 4 * w, bm);
            settle();
            rd(1, 8'h7C, v); chk("R5 R3 idle summary", v, 32'h0);
            src_i[n] = ~pol;
            settle();
            rd(1, 8'h38 + 4 * w, v); chk("R6 R11 out0 word", v, rt ? bm : 32'h0);
            rd(1, 8'h1C + 4 * w, v); chk("R6 R11 out1 word", v, rt ? 32'h0 : bm);
            rd(1, 8'h7C, v); chk("R8 summary", v, rt ? (32'h1 << (8 + w)) : (32'h1 << w));
            chk("R9 irq pins", {30'd0, irq_out0, irq_out1}, {30'd0, rt, ~rt});
            src_i[n] = pol;
            settle();
            rd(1, (rt ? 8'h38 : 8'h1C) + 4 * w, v);
            if (typ) chk("R3 edge held", v, bm);
            else     chk("R5 level released", v, 32'h0);
            if (typ) begin
                wr(1, 8'h00 + 4 * w, bm);
                rd(1, (rt ? 8'h38 : 8'h1C) + 4 * w, v); chk("R4 cleared", v, 32'h0);
            end
            wr(0, 8'h54 + 4 * w, 32'h0);
            wr(0, 8'h00 + 4 * w, 32'hFFFF_FFFF);
            wr(0, 8'h1C + 4 * w, 32'h0);
            wr(0, 8'h38 + 4 * w, 32'hFFFF_FFFF);
            src_i[n] = 1'b0;
        end
        settle();
        clear_all();

        // R7 and R4: masked latch, per-bit clear across two words
        wr(0, 8'h54 + 4, 32'h0000_0100);
        src_i[5] = 1'b1; src_i[40] = 1'b1;
        settle();
        src_i[5] = 1'b0; src_i[40] = 1'b0;
        settle();
        rd(1, 8'h38, v); chk("R7 masked word0", v, 32'h0);
        rd(1, 8'h38 + 4, v); chk("R7 enabled word1", v, 32'h0000_0100);
        wr(0, 8'h54, 32'h0000_0020);
        rd(1, 8'h38, v); chk("R7 latched shows on enable", v, 32'h0000_0020);
        wr(1, 8'h00, 32'h0000_0020);
        rd(1, 8'h38, v); chk("R4 bit cleared", v, 32'h0);
        rd(1, 8'h38 + 4, v); chk("R4 other word kept", v, 32'h0000_0100);
        chk("R9 irq0 still high", {31'd0, irq_out0}, 32'h1);
        wr(1, 8'h04, 32'hFFFF_FEFF);
        rd(1, 8'h38 + 4, v); chk("R4 zero bit kept", v, 32'h0000_0100);
        wr(1, 8'h04, 32'h0000_0100);
        rd(1, 8'h7C, v); chk("R4 all cleared summary", v, 32'h0);
        chk("R9 irq low", {30'd0, irq_out0, irq_out1}, 32'h0);

        // R10: unmapped, misaligned, write-only and read-only accesses
        rd(0, 8'h70, v); chk("R10 cfg unmapped", v, 32'h0);
        rd(0, 8'h7C, v); chk("R10 cfg 0x7C", v, 32'h0);
        rd(0, 8'h01, v); chk("R10 misaligned", v, 32'h0);
        rd(1, 8'h54, v); chk("R10 st unmapped", v, 32'h0);
        wr(0, 8'h00, 32'h1234_5678);
        rd(1, 8'h00, v); chk("R10 clear reads zero", v, 32'h0);
        wr(0, 8'h00, 32'hFFFF_FFFF);
        wr(1, 8'h1C, 32'hFFFF_FFFF);
        wr(1, 8'h38, 32'hFFFF_FFFF);
        wr(1, 8'h7C, 32'hFFFF_FFFF);
        wr(0, 8'h70, 32'hFFFF_FFFF);
        rd(1, 8'h1C, v); chk("R10 out1 ro", v, 32'h0);
        rd(1, 8'h38, v); chk("R10 out0 ro", v, 32'h0);
        rd(1, 8'h7C, v); chk("R10 summary ro", v, 32'h0);
        rd(0, 8'h54 + 24, v); chk("R10 en6 untouched", v, 32'h0);
        rd(0, 8'h38 + 24, v); chk("R10 route6 untouched", v, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule